// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This controller lives on the host side of a link and owns the active-low hard-reset line of a downstream timing device. The device reset stays low from power-up for as long as the master clock is reported unstable. Once the clock is reported stable, the controller counts a minimum hold time in master-clock cycles. It then releases the reset through a chain of synchronising flops, so that the rising edge always lines up with the clock.

After release, the controller issues one register write on a simple strobe/acknowledge bus. The write sets the device's error-reset bit. When that write has been acknowledged, a ready flag goes high. While ready, a host may request a soft reset. The soft reset is a one-cycle pulse that re-initialises device registers and never touches the hard-reset line.

Any loss of clock stability re-asserts the hard reset and starts the hold count from zero. The host's own synchronous reset does the same.

Top module: `pwrseq_ctrl`

## Requirements
- R1: While `rst` is sampled high, after that edge `dev_rst_n_o`, `wr_en_o`, `ready_o` and `soft_rst_o` are all 0.
- R2: When `clk_ok_i` is sampled low, `dev_rst_n_o` is 0 after that edge. The hold count restarts from zero when stability returns.
- R3: With HOLD = max(MIN_PULSE, CLK_MHZ*HOLD_US), `dev_rst_n_o` goes to 1 after exactly HOLD+2 consecutive edges with `clk_ok_i`=1 and `rst`=0. With the defaults this is 20 µs at 200 MHz.
- R4: Release passes through two clock-driven flops. `dev_rst_n_o` only rises at a clock edge, after `clk_ok_i` has been high at the two preceding edges.
- R5: One edge after release, `wr_en_o` goes to 1 with `wr_addr_o`=0x19 and `wr_data_o`=0x08 (only bit 3 set). It stays at 1 until `wr_ack_i` is sampled, and the write is issued only once per bring-up.
- R6: `ready_o` goes to 1 on the edge where `wr_ack_i` is sampled with `wr_en_o`=1, and `wr_en_o` drops on that same edge. `ready_o` is cleared by R1 or R2.
- R7: Every low pulse of `dev_rst_n_o` lasts at least MIN_PULSE (3) clock cycles.
- R8: `soft_req_i` sampled while `ready_o`=1 gives `soft_rst_o`=1 for the following cycle, and `dev_rst_n_o` and `ready_o` are not changed. A request made while not ready is ignored.
- R9: `wr_ack_i` outside an outstanding write has no effect on `wr_en_o` or `ready_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high host reset |
| clk_ok_i | input | 1 | Master clock reported stable |
| soft_req_i | input | 1 | Soft-reset request |
| wr_ack_i | input | 1 | Register write acknowledge |
| dev_rst_n_o | output | 1 | Active-low hard reset to device |
| soft_rst_o | output | 1 | One-cycle soft-reset pulse |
| wr_en_o | output | 1 | Register write strobe, held until acknowledged |
| wr_addr_o | output | ADDR_W | Register write address |
| wr_data_o | output | DATA_W | Register write data |
| ready_o | output | 1 | Bring-up complete |

## Verification
The properties assume that `clk_ok_i`, `soft_req_i` and `wr_ack_i` are already synchronous to `clk`. They also assume that host reset is only ever applied with the clock running. The stimulus changes every input on the falling edge, so each value is settled well before the edge that samples it.

The bench drops stability for a single cycle in the middle of a hold. It also pulses the acknowledge while no write is outstanding. Both stay within those assumptions while exercising the restart and ignore paths.

// File: rtl/pwrseq_pkg.sv
`timescale 1ns/1ps
package pwrseq_pkg;

  typedef enum logic [1:0] {
    PH_HOLD,
    PH_RELEASE,
    PH_WRITE,
    PH_READY
  } phase_t;

  function automatic int unsigned hold_cycles(int unsigned mhz, int unsigned us,
                                              int unsigned min_pulse);
    int unsigned p;
    p = mhz * us;
    return (p < min_pulse) ? min_pulse : p;
  endfunction

endpackage

// File: rtl/pwrseq_hold_timer.sv
`timescale 1ns/1ps
module pwrseq_hold_timer #(
  parameter int unsigned LIMIT = 4000
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  output logic expired
);

  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  assign expired = (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (clr) begin
      cnt <= '0;
    end else if (run && !expired) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/pwrseq_release_sync.sv
`timescale 1ns/1ps
module pwrseq_release_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic force_low,
  input  logic release_req,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (force_low) chain <= '0;
        else           chain <= release_req;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (force_low) chain <= '0;
        else           chain <= {chain[STAGES-2:0], release_req};
      end
    end
  endgenerate

  assign rst_n_o = chain[STAGES-1];

endmodule

// File: rtl/pwrseq_ctrl.sv
`timescale 1ns/1ps
module pwrseq_ctrl #(
  parameter int unsigned CLK_MHZ     = 200,
  parameter int unsigned HOLD_US     = 20,
  parameter int unsigned MIN_PULSE   = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned DATA_W      = 8,
  parameter logic [ADDR_W-1:0] ERR_ADDR = 8'h19,
  parameter int unsigned ERR_BIT     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clk_ok_i,
  input  logic              soft_req_i,
  input  logic              wr_ack_i,
  output logic              dev_rst_n_o,
  output logic              soft_rst_o,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              ready_o
);

  import pwrseq_pkg::*;

  localparam int unsigned HOLD_CYC = hold_cycles(CLK_MHZ, HOLD_US, MIN_PULSE);
  localparam logic [DATA_W-1:0] ERR_MASK = {{(DATA_W-1){1'b0}}, 1'b1} << ERR_BIT;

  phase_t phase;
  logic   force_hold;
  logic   hold_done;

  assign force_hold = rst | ~clk_ok_i;

  pwrseq_hold_timer #(.LIMIT(HOLD_CYC)) u_timer (
    .clk     (clk),
    .clr     (force_hold),
    .run     (phase == PH_HOLD),
    .expired (hold_done)
  );

  pwrseq_release_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk         (clk),
    .force_low   (force_hold),
    .release_req (phase != PH_HOLD),
    .rst_n_o     (dev_rst_n_o)
  );

  always_ff @(posedge clk) begin
    if (force_hold) begin
      phase     <= PH_HOLD;
      wr_en_o   <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
      ready_o   <= 1'b0;
    end else begin
      unique case (phase)
        PH_HOLD: begin
          if (hold_done) phase <= PH_RELEASE;
        end
        PH_RELEASE: begin
          if (dev_rst_n_o) begin
            phase     <= PH_WRITE;
            wr_en_o   <= 1'b1;
            wr_addr_o <= ERR_ADDR;
            wr_data_o <= ERR_MASK;
          end
        end
        PH_WRITE: begin
          if (wr_ack_i) begin
            phase     <= PH_READY;
            wr_en_o   <= 1'b0;
            wr_addr_o <= '0;
            wr_data_o <= '0;
            ready_o   <= 1'b1;
          end
        end
        default: phase <= PH_READY;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (force_hold) soft_rst_o <= 1'b0;
    else            soft_rst_o <= ready_o & soft_req_i;
  end

endmodule

// File: rtl/pwrseq_ctrl_chk.sv
`timescale 1ns/1ps
module pwrseq_ctrl_chk #(
  parameter int unsigned HOLD_CYC  = 4000,
  parameter int unsigned MIN_PULSE = 3
) (
  input logic clk,
  input logic rst,
  input logic clk_ok_i,
  input logic wr_ack_i,
  input logic dev_rst_n_o,
  input logic soft_rst_o,
  input logic wr_en_o,
  input logic ready_o
);

  int unsigned ok_run;
  int unsigned low_run;

  always_ff @(posedge clk) begin
    if (rst || !clk_ok_i) ok_run <= 0;
    else if (ok_run < 32'h7fff_ffff) ok_run <= ok_run + 1;
  end

  always_ff @(posedge clk) begin
    if (dev_rst_n_o) low_run <= 0;
    else if (low_run < 32'h7fff_ffff) low_run <= low_run + 1;
  end

  AST_LOW_WHILE_UNSTABLE: assert property (@(posedge clk) disable iff (rst)
    !clk_ok_i |=> !dev_rst_n_o); // R2

  AST_HOLD_ELAPSED: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_rst_n_o) |-> ok_run >= HOLD_CYC); // R3

  AST_RELEASE_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_rst_n_o) |-> $past(clk_ok_i, 1) && $past(clk_ok_i, 2)); // R4

  AST_WRITE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (rst)
    wr_en_o |-> dev_rst_n_o); // R5

  AST_READY_ON_ACK: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $past(wr_en_o && wr_ack_i)); // R6

  AST_MIN_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(dev_rst_n_o) |-> low_run >= MIN_PULSE); // R7

  AST_SOFT_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
    soft_rst_o |-> ready_o && dev_rst_n_o); // R8

endmodule

bind pwrseq_ctrl pwrseq_ctrl_chk #(
  .HOLD_CYC  (HOLD_CYC),
  .MIN_PULSE (MIN_PULSE)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .clk_ok_i    (clk_ok_i),
  .wr_ack_i    (wr_ack_i),
  .dev_rst_n_o (dev_rst_n_o),
  .soft_rst_o  (soft_rst_o),
  .wr_en_o     (wr_en_o),
  .ready_o     (ready_o)
);

// File: tb/pwrseq_ctrl_test.sv
`timescale 1ns/1ps
module pwrseq_ctrl_test;

  localparam int MHZ = 200;
  localparam int US  = 1;
  localparam int H   = (MHZ * US < 3) ? 3 : MHZ * US;

  logic clk = 1'b0;
  logic rst, clk_ok, soft_req, ack;
  logic dev_rst_n, soft_rst, wr_en, ready;
  logic [7:0] wr_addr, wr_data;

  int n_run = 0;
  int n_fail = 0;
  bit checking = 0;

  int m_cnt = 0;
  bit m_wr = 0, m_rdy = 0, m_soft = 0, m_wrote = 0;

  always #2.5 clk = ~clk;

  pwrseq_ctrl #(.CLK_MHZ(MHZ), .HOLD_US(US)) uut (
    .clk(clk), .rst(rst), .clk_ok_i(clk_ok), .soft_req_i(soft_req),
    .wr_ack_i(ack), .dev_rst_n_o(dev_rst_n), .soft_rst_o(soft_rst),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .ready_o(ready)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on each rising edge
  always @(posedge clk) begin
    if (rst || !clk_ok) begin
      m_cnt = 0; m_wr = 0; m_rdy = 0; m_soft = 0; m_wrote = 0;
    end else begin
      m_soft = m_rdy && soft_req;
      if (m_cnt < H + 3) m_cnt++;
      if (m_wr && ack) begin
        m_wr = 0; m_rdy = 1;
      end else if (m_cnt == H + 3 && !m_wrote) begin
        m_wr = 1; m_wrote = 1;
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      chk("R3 dev_rst_n", dev_rst_n, (m_cnt >= H + 2));
      chk("R5 wr_en", wr_en, m_wr);
      if (m_wr) begin
        chk("R5 wr_addr", wr_addr, 8'h19);
        chk("R5 wr_data", wr_data, 8'h08);
      end
      chk("R6 ready", ready, m_rdy);
      chk("R8 soft_rst", soft_rst, m_soft);
    end
  end

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  task automatic ack_write();
    while (!wr_en) @(negedge clk);
    repeat (3) @(negedge clk);
    ack = 1;
    @(negedge clk);
    ack = 0;
  endtask

  initial begin
    int n;
    int low;
    rst = 1; clk_ok = 0; soft_req = 0; ack = 0;
    repeat (4) @(negedge clk);
    checking = 1;
    chk("R1 reset dev_rst_n", dev_rst_n, 0);
    chk("R1 reset wr_en", wr_en, 0);
    chk("R1 reset ready", ready, 0);
    rst = 0;
    repeat (10) @(negedge clk);
    chk("R2 unstable holds reset", dev_rst_n, 0);

    // first bring-up: spurious ack and early soft request during hold
    clk_ok = 1;
    n = 0;
    while (!dev_rst_n && n < 3 * H) begin
      @(negedge clk);
      n++;
      if (n == 50) ack = 1;
      if (n == 51) begin
        ack = 0;
        chk("R9 stray ack wr_en", wr_en, 0);
        chk("R9 stray ack ready", ready, 0);
      end
      if (n == 60) soft_req = 1;
      if (n == 61) begin
        soft_req = 0;
        chk("R8 soft ignored before ready", soft_rst, 0);
      end
    end
    chk("R4 release edge count", n, H + 2);
    ack_write();
    chk("R6 ready after ack", ready, 1);
    ack = 1;
    repeat (3) @(negedge clk);
    ack = 0;
    chk("R9 ack while ready", ready, 1);
    chk("R9 no rewrite", wr_en, 0);

    soft_req = 1;
    @(negedge clk);
    soft_req = 0;
    chk("R8 soft pulse", soft_rst, 1);
    chk("R8 hard untouched", dev_rst_n, 1);
    chk("R8 ready untouched", ready, 1);
    @(negedge clk);
    chk("R8 soft single cycle", soft_rst, 0);

    // one-cycle stability glitch after ready: measure low width
    clk_ok = 0;
    @(negedge clk);
    clk_ok = 1;
    chk("R2 glitch asserts reset", dev_rst_n, 0);
    chk("R2 glitch clears ready", ready, 0);
    low = 1;
    while (!dev_rst_n && low < 3 * H) begin
      @(negedge clk);
      if (!dev_rst_n) low++;
    end
    chk("R7 low pulse width ok", (low >= 3), 1);
    ack_write();

    // glitch in the middle of a hold restarts the count
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk("R1 mid-run reset", dev_rst_n, 0);
    chk("R1 mid-run ready", ready, 0);
    repeat (100) @(negedge clk);
    clk_ok = 0;
    @(negedge clk);
    clk_ok = 1;
    n = 0;
    while (!dev_rst_n && n < 3 * H) begin
      @(negedge clk);
      n++;
    end
    chk("R2 count restarted", n, H + 2);
    ack_write();
    repeat (5) @(negedge clk);
    chk("R6 final ready", ready, 1);
    summary();
  end

endmodule